// File: doc/BRIEF.md
# Three-Stage Interlocked Pipeline Core

A small in-order processor core built as three stages. The first stage presents the program counter to an instruction memory, takes the word back in the same cycle, decodes it and reads its source register. The second stage computes the result. The third stage commits the result to the register file or to data memory and reports the instruction as retired. With no dependencies, a new instruction enters every cycle and three instructions are in flight at once.

There is no forwarding from the execute stage. When the instruction being fetched needs a register that the instruction one stage ahead will write, fetch holds for one cycle and a bubble goes down the pipe in its place. Older work keeps moving. A jump is resolved in the execute stage. The single younger instruction already fetched is dropped, and fetch restarts at the absolute target.

An instruction word is 16 bits, with fields listed from the most significant bit: a 3-bit opcode at [15:13], a destination register at [12:11], a source register at [10:9] and a 9-bit immediate or address at [8:0]. The opcodes are:

| Opcode | Operation |
|---|---|
| 0 | No operation |
| 1 | Load immediate into the destination register |
| 2 | Copy the source register into the destination register |
| 3 | Add the immediate to the destination register |
| 4 | Store the source register at the immediate address |
| 5 | Jump to the immediate address |

Top module: `toy_pipe3_core`

## Requirements
- R1: While rst_ni is low, retire_o and dmem_we_o are 0 and imem_addr_o is 0. All four registers read as 0 after reset.
- R2: The first instruction after reset retires in the second cycle after release. Independent instructions retire on consecutive cycles, and the fetch address steps by one each cycle.
- R3: Opcode 1 writes the low 8 bits of the immediate into the destination register. An immediate of 0x1FF gives 0xFF.
- R4: Opcode 2 copies the source register into the destination register.
- R5: Opcode 3 adds the low 8 bits of the immediate to the destination register, modulo 256. For example, 200 + 100 gives 44.
- R6: Opcode 4 pulses dmem_we_o in its retire cycle, with dmem_addr_o set to the immediate and dmem_wdata_o set to the source register.
- R7: An instruction that reads a register written by the instruction directly ahead of it is held for one cycle. A single bubble is inserted, so its retire comes two cycles after the producer's retire.
- R8: An instruction that reads a register written two instructions earlier is not held. It sees the new value through write-through in the register file.
- R9: Opcode 5 retires. The one instruction fetched behind it never retires and never writes. The next instruction to retire is the one at the target, two cycles after the jump.
- R10: Opcode 0 retires with retire_op_o = 0, takes one issue slot and writes nothing.
- R11: Opcodes 6 and 7 behave as opcode 0. They retire with retire_op_o = 0 and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 9 | Instruction fetch address (program counter) |
| imem_data_i | input | 16 | Instruction word returned in the same cycle |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_addr_o | output | 9 | Data memory write address |
| dmem_wdata_o | output | 8 | Data memory write data |
| retire_o | output | 1 | One-cycle pulse for each non-bubble instruction leaving the last stage |
| retire_op_o | output | 3 | Opcode of the retiring instruction (0 for opcodes 0, 6 and 7) |
| retire_rd_o | output | 2 | Destination field of the retiring instruction |

## Verification
The bench builds the core with its defaults: 8-bit data, four registers and a 9-bit immediate. With a 9-bit immediate, a value wider than the data path can be loaded, which exercises truncation. It also allows an absolute jump well past the fall-through path. With four registers, a producer, an unrelated instruction and a consumer can be placed at distance two, to show that write-through removes the stall. Register contents are observed only through stores into the bench's data memory. Pipeline timing is observed only through the cycles in which retire_o pulses.

// File: rtl/toy_pipe3_pkg.sv
package toy_pipe3_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LDI  = 3'd1,
    OP_MOV  = 3'd2,
    OP_ADDI = 3'd3,
    OP_ST   = 3'd4,
    OP_JMP  = 3'd5
  } op_e;

  // Undefined codes collapse to NOP.
  function automatic op_e decode_op(input logic [2:0] raw);
    case (raw)
      3'd1:    return OP_LDI;
      3'd2:    return OP_MOV;
      3'd3:    return OP_ADDI;
      3'd4:    return OP_ST;
      3'd5:    return OP_JMP;
      default: return OP_NOP;
    endcase
  endfunction

  function automatic logic writes_reg(input op_e op);
    return (op == OP_LDI) || (op == OP_MOV) || (op == OP_ADDI);
  endfunction

  // ADDI reads its destination; MOV and ST read the source field.
  function automatic logic src_is_rd(input op_e op);
    return op == OP_ADDI;
  endfunction

  function automatic logic reads_reg(input op_e op);
    return (op == OP_MOV) || (op == OP_ST) || (op == OP_ADDI);
  endfunction

endpackage

// File: rtl/tp3_fetch.sv
module tp3_fetch #(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic          flush_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (flush_i) pc_q <= target_i;
    else if (!stall_i) pc_q <= pc_q + AW'(1);
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/tp3_regfile.sv
module tp3_regfile #(
  parameter int REG_N  = 4,
  parameter int DATA_W = 8,
  localparam int RAW   = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RAW-1:0]    waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [RAW-1:0]    raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[g] <= '0;
      else if (we_i && waddr_i == RAW'(g))  regs_q[g] <= wdata_i;
    end
  end

  // Write-through: a commit this cycle is seen by this cycle's read.
  assign rdata_o = (we_i && waddr_i == raddr_i) ? wdata_i : regs_q[raddr_i];
endmodule

// File: rtl/tp3_hazard.sv
module tp3_hazard #(
  parameter int RAW = 2
) (
  input  logic           fetch_reads_i,
  input  logic [RAW-1:0] fetch_src_i,
  input  logic           ex_vld_i,
  input  logic           ex_writes_i,
  input  logic [RAW-1:0] ex_rd_i,
  input  logic           ex_jmp_i,
  output logic           stall_o,
  output logic           flush_o
);
  logic raw_dep;

  assign flush_o = ex_vld_i && ex_jmp_i;
  assign raw_dep = fetch_reads_i && ex_vld_i && ex_writes_i && (ex_rd_i == fetch_src_i);
  // A flushed fetch slot is discarded anyway, so the jump takes priority.
  assign stall_o = raw_dep && !flush_o;
endmodule

// File: rtl/tp3_alu.sv
module tp3_alu
  import toy_pipe3_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_LDI:  res_o = imm_i;
      OP_MOV:  res_o = opa_i;
      OP_ADDI: res_o = opa_i + imm_i;
      OP_ST:   res_o = opa_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/toy_pipe3_core.sv
module toy_pipe3_core
  import toy_pipe3_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_N  = 4,
  parameter int IMM_W  = 9,
  localparam int RAW     = $clog2(REG_N),
  localparam int OP_W    = 3,
  localparam int INSTR_W = OP_W + 2 * RAW + IMM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [IMM_W-1:0]   imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  output logic               dmem_we_o,
  output logic [IMM_W-1:0]   dmem_addr_o,
  output logic [DATA_W-1:0]  dmem_wdata_o,
  output logic               retire_o,
  output logic [OP_W-1:0]    retire_op_o,
  output logic [RAW-1:0]     retire_rd_o
);
  localparam int IMM_LSB = 0;
  localparam int RS_LSB  = IMM_W;
  localparam int RD_LSB  = IMM_W + RAW;
  localparam int OP_LSB  = IMM_W + 2 * RAW;

  // Stage 1: fetch / decode / operand read
  op_e              f_op;
  logic [RAW-1:0]   f_rd, f_rs, f_src;
  logic [IMM_W-1:0] f_imm;
  logic [DATA_W-1:0] f_opa;
  logic             stall, flush;

  assign f_op  = decode_op(imem_data_i[OP_LSB +: OP_W]);
  assign f_rd  = imem_data_i[RD_LSB +: RAW];
  assign f_rs  = imem_data_i[RS_LSB +: RAW];
  assign f_imm = imem_data_i[IMM_LSB +: IMM_W];
  assign f_src = src_is_rd(f_op) ? f_rd : f_rs;

  // Stage 2: execute
  logic              ex_vld;
  op_e               ex_op;
  logic [RAW-1:0]    ex_rd;
  logic [IMM_W-1:0]  ex_imm;
  logic [DATA_W-1:0] ex_opa, ex_res;

  // Stage 3: commit
  logic              wb_vld;
  op_e               wb_op;
  logic [RAW-1:0]    wb_rd;
  logic [IMM_W-1:0]  wb_addr;
  logic [DATA_W-1:0] wb_res;
  logic              wb_we;

  tp3_fetch #(.AW(IMM_W)) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stall_i  (stall),
    .flush_i  (flush),
    .target_i (ex_imm),
    .pc_o     (imem_addr_o)
  );

  tp3_hazard #(.RAW(RAW)) u_hazard (
    .fetch_reads_i (reads_reg(f_op)),
    .fetch_src_i   (f_src),
    .ex_vld_i      (ex_vld),
    .ex_writes_i   (writes_reg(ex_op)),
    .ex_rd_i       (ex_rd),
    .ex_jmp_i      (ex_op == OP_JMP),
    .stall_o       (stall),
    .flush_o       (flush)
  );

  tp3_regfile #(.REG_N(REG_N), .DATA_W(DATA_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wb_we),
    .waddr_i (wb_rd),
    .wdata_i (wb_res),
    .raddr_i (f_src),
    .rdata_o (f_opa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_vld <= 1'b0;
      ex_op  <= OP_NOP;
      ex_rd  <= '0;
      ex_imm <= '0;
      ex_opa <= '0;
    end else if (stall || flush) begin
      ex_vld <= 1'b0;
      ex_op  <= OP_NOP;
    end else begin
      ex_vld <= 1'b1;
      ex_op  <= f_op;
      ex_rd  <= f_rd;
      ex_imm <= f_imm;
      ex_opa <= f_opa;
    end
  end

  tp3_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (ex_op),
    .opa_i (ex_opa),
    .imm_i (DATA_W'(ex_imm)),
    .res_o (ex_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_vld  <= 1'b0;
      wb_op   <= OP_NOP;
      wb_rd   <= '0;
      wb_addr <= '0;
      wb_res  <= '0;
    end else begin
      wb_vld  <= ex_vld;
      wb_op   <= ex_op;
      wb_rd   <= ex_rd;
      wb_addr <= ex_imm;
      wb_res  <= ex_res;
    end
  end

  assign wb_we        = wb_vld && writes_reg(wb_op);
  assign dmem_we_o    = wb_vld && (wb_op == OP_ST);
  assign dmem_addr_o  = wb_addr;
  assign dmem_wdata_o = wb_res;
  assign retire_o     = wb_vld;
  assign retire_op_o  = wb_op;
  assign retire_rd_o  = wb_rd;
endmodule

// File: rtl/tp3_checker.sv
module tp3_checker #(
  parameter int AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stall,
  input logic          flush,
  input logic [AW-1:0] jmp_tgt,
  input logic          ex_vld,
  input logic [AW-1:0] imem_addr_o,
  input logic          dmem_we_o,
  input logic          retire_o,
  input logic [2:0]    retire_op_o
);
  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall && !flush) |=> imem_addr_o == AW'($past(imem_addr_o) + AW'(1)));

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> $stable(imem_addr_o));

  assert_stall_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> !ex_vld);

  assert_flush_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> imem_addr_o == $past(jmp_tgt));

  assert_flush_bubble_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !ex_vld);

  assert_store_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (retire_o && retire_op_o == 3'd4));
endmodule

bind toy_pipe3_core tp3_checker #(.AW(IMM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stall       (stall),
  .flush       (flush),
  .jmp_tgt     (ex_imm),
  .ex_vld      (ex_vld),
  .imem_addr_o (imem_addr_o),
  .dmem_we_o   (dmem_we_o),
  .retire_o    (retire_o),
  .retire_op_o (retire_op_o)
);

// File: tb/sim_toy_pipe3_core.sv
`timescale 1ns/1ps
module sim_toy_pipe3_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  imem_addr;
  logic [15:0] imem_data;
  logic        dmem_we;
  logic [8:0]  dmem_addr;
  logic [7:0]  dmem_wdata;
  logic        retire;
  logic [2:0]  retire_op;
  logic [1:0]  retire_rd;

  logic [15:0] imem [512];
  logic [7:0]  dmem [512];
  int          cyc;
  int          nlog;
  int          ret_cyc [64];
  int          ret_op  [64];
  int          nchk = 0;
  int          errs = 0;

  always #2.5 clk = ~clk;

  toy_pipe3_core u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_we_o    (dmem_we),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .retire_o     (retire),
    .retire_op_o  (retire_op),
    .retire_rd_o  (retire_rd)
  );

  assign imem_data = imem[imem_addr];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr] = dmem_wdata;
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst_ni) nlog <= 0;
    else if (retire && nlog < 64) begin
      ret_cyc[nlog] <= cyc;
      ret_op[nlog]  <= int'(retire_op);
      nlog          <= nlog + 1;
    end
  end

  function automatic logic [15:0] enc(int op, int rd, int rs, int imm);
    return {op[2:0], rd[1:0], rs[1:0], imm[8:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 512; i++) imem[i] = 16'h0000;
  endtask

  task automatic run_prog(int n);
    @(negedge clk) rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_indep();
    clear_imem();
    imem[0] = enc(1, 0, 0, 5);
    imem[1] = enc(1, 1, 0, 7);
    imem[2] = enc(1, 2, 0, 9);
    imem[3] = enc(1, 3, 0, 9'h1FF);
    imem[4] = enc(4, 0, 0, 100);
    imem[5] = enc(4, 0, 1, 101);
    imem[6] = enc(4, 0, 2, 102);
    imem[7] = enc(4, 0, 3, 103);
    run_prog(20);
    chk("R2 first retire cycle", ret_cyc[0], 2);
    for (int k = 0; k < 7; k++) chk("R2 back-to-back gap", ret_cyc[k+1] - ret_cyc[k], 1);
    chk("R3 retire opcode", ret_op[0], 1);
    chk("R3 load 5", int'(dmem[100]), 5);
    chk("R3 load 7", int'(dmem[101]), 7);
    chk("R6 store addr 102", int'(dmem[102]), 9);
    chk("R3 truncated immediate", int'(dmem[103]), 255);
  endtask

  task automatic t_reset();
    clear_imem();
    imem[0] = enc(4, 0, 1, 9'h070);
    @(negedge clk) rst_ni = 1'b0;
    #1;
    chk("R1 retire low in reset", int'(retire), 0);
    chk("R1 we low in reset", int'(dmem_we), 0);
    chk("R1 pc zero in reset", int'(imem_addr), 0);
    dmem[9'h070] = 8'h5A;
    run_prog(8);
    chk("R1 register cleared", int'(dmem[9'h070]), 0);
  endtask

  task automatic t_hazard();
    clear_imem();
    imem[0] = enc(1, 0, 0, 40);
    imem[1] = enc(2, 1, 0, 0);
    imem[2] = enc(3, 1, 0, 20);
    imem[3] = enc(4, 0, 1, 9'h030);
    run_prog(20);
    chk("R7 MOV held one cycle", ret_cyc[1] - ret_cyc[0], 2);
    chk("R7 ADDI held one cycle", ret_cyc[2] - ret_cyc[1], 2);
    chk("R7 ST held one cycle", ret_cyc[3] - ret_cyc[2], 2);
    chk("R4 copy opcode", ret_op[1], 2);
    chk("R5 R4 dependent result", int'(dmem[9'h030]), 60);
  endtask

  task automatic t_dist2();
    clear_imem();
    imem[0] = enc(1, 2, 0, 3);
    imem[1] = enc(1, 3, 0, 4);
    imem[2] = enc(2, 0, 2, 0);
    imem[3] = enc(4, 0, 0, 9'h040);
    run_prog(20);
    chk("R8 no stall at distance two", ret_cyc[2] - ret_cyc[1], 1);
    chk("R7 ST after MOV held", ret_cyc[3] - ret_cyc[2], 2);
    chk("R8 write-through value", int'(dmem[9'h040]), 3);
  endtask

  task automatic t_wrap();
    clear_imem();
    imem[0] = enc(1, 0, 0, 200);
    imem[1] = enc(0, 0, 0, 5);
    imem[2] = enc(7, 0, 0, 9'h1FF);
    imem[3] = enc(3, 0, 0, 100);
    imem[4] = enc(0, 0, 0, 0);
    imem[5] = enc(0, 0, 0, 0);
    imem[6] = enc(4, 0, 0, 9'h050);
    run_prog(20);
    chk("R10 NOP retires as op 0", ret_op[1], 0);
    chk("R10 NOP takes one slot", ret_cyc[1] - ret_cyc[0], 1);
    chk("R11 undefined code retires as op 0", ret_op[2], 0);
    chk("R5 R11 wrapped sum", int'(dmem[9'h050]), 44);
  endtask

  task automatic t_jump();
    clear_imem();
    imem[0]  = enc(1, 0, 0, 1);
    imem[1]  = enc(5, 0, 0, 10);
    imem[2]  = enc(1, 0, 0, 99);
    imem[3]  = enc(4, 0, 0, 9'h061);
    imem[10] = enc(4, 0, 0, 9'h060);
    dmem[9'h061] = 8'hAA;
    run_prog(20);
    chk("R9 jump retires", ret_op[1], 5);
    chk("R9 target after one bubble", ret_cyc[2] - ret_cyc[1], 2);
    chk("R9 next retire is target ST", ret_op[2], 4);
    chk("R9 flushed LDI wrote nothing", int'(dmem[9'h060]), 1);
    chk("R9 fall-through never ran", int'(dmem[9'h061]), 8'hAA);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) dmem[i] = 8'h00;
    t_indep();
    t_reset();
    t_hazard();
    t_dist2();
    t_wrap();
    t_jump();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule